// File: doc/BRIEF.md
# Direct-Sequence Despreader with Majority Bit Decision

This block recovers a short message from a direct-sequence spread frame. A frame holds 60 chips in four segments of 15. Each segment carries one message bit. A one is sent as the 15-chip spreading code as it stands. A zero is sent as the inverted code. The block builds the same code locally with a 4-stage linear feedback shift register. It compares every received chip with the local code chip. For each segment it counts the chips that agree, and it decides the bit by majority. A segment can therefore contain a few corrupted chips and still decode correctly.

A frame arrives in one of two ways. The first is a 60-bit parallel word, captured with a load strobe and then consumed internally at one chip per clock. The second is a serial stream of chips, each marked by a valid flag, and the stream may contain idle gaps. Frames are assumed to be aligned to segment boundaries. The recovered 4-bit word is registered and marked by a one-cycle done pulse.

Top module: `dsd_despreader`

## Requirements
- R1: The local code is the 15-chip sequence 0,0,1,0,0,0,1,1,1,1,0,1,0,1,1, starting from its first chip at the start of every segment. A segment equal to this code decodes to 1, and a segment equal to its bitwise inverse decodes to 0.
- R2: A chip agrees when it XNOR the local code chip is 1. A segment with 8 or more agreements decodes to 1, otherwise to 0. Up to 7 flipped chips in a segment leave the bit unchanged, and 8 flipped chips in a segment of a 1 bit change it to 0.
- R3: Each 60-chip frame gives exactly 4 bits. The first segment received goes to `msg_out[3]` and the last to `msg_out[0]`. A frame of code, code, code, inverted code gives 1110, and the messages 0000, 0001, 0101, 0110, 1001, 1010, 1110 and 1111 come back unchanged after spreading.
- R4: `frame_load` high at a clock edge while no parallel frame is in progress captures `frame_word`. Bit 59 is the first chip and bit 0 the last. The chips are consumed on the following 60 edges, and `msg_done` is high in the cycle after the 60th of those edges.
- R5: In serial mode a chip is taken at each edge where `chip_valid` is high. Cycles where `chip_valid` is low leave all frame progress unchanged. `msg_done` is high in the cycle after the edge that takes the 60th chip.
- R6: The code generator state is never all-zero. Reset loads a nonzero seed.
- R7: The agreement count restarts from zero at every segment boundary, so a segment's decision does not depend on the segments before it.
- R8: `msg_done` is high for exactly one cycle per frame. `msg_out` changes only in a cycle where `msg_done` is high and holds its value until the next frame completes.
- R9: While a parallel frame is being consumed, `chip_valid`, `chip_in` and further `frame_load` pulses are ignored. The decoded result is that of the loaded frame.
- R10: A low `rst_n` at a clock edge clears `msg_out` to 0 and `msg_done` to 0 and discards any partial frame.
- R11: An accepted `frame_load` discards any partial serial frame and restarts decoding at the first segment. A `chip_valid` in the same cycle as the accepted load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_load | input | 1 | Strobe that captures a parallel frame |
| frame_word | input | 60 | Parallel frame; bit 59 is the first chip |
| chip_valid | input | 1 | Serial chip qualifier |
| chip_in | input | 1 | Serial chip value |
| msg_out | output | 4 | Recovered message; first segment in bit 3 |
| msg_done | output | 1 | One-cycle pulse when `msg_out` is updated |

## Verification
A parallel frame's result is due 60 edges after the edge that accepts the load. A serial frame's result is due on the edge that takes its 60th valid chip, however many idle cycles come between the chips. The bench runs a behavioural model from the same input samples the design sees at each rising edge. It compares `msg_done` and `msg_out` on every falling edge, so a result that arrives one cycle early or late is caught. Directed checks also count falling edges after a load and confirm that the done pulse is absent at edge 59 and present at edge 60.

// File: rtl/dsd_pkg.sv
// Package: shared defaults and helpers for the despreader.
// Assumes one message bit per code period and segment-aligned frames.
package dsd_pkg;

    localparam int DEF_CHIPS_PER_BIT = 15;
    localparam int DEF_BITS_PER_FRAME = 4;
    localparam int DEF_LFSR_W = 4;

    // Majority threshold: more than half of the chips must agree.
    function automatic int majority_threshold(input int chips);
        return chips / 2 + 1;
    endfunction

endpackage

// File: rtl/dsd_code_gen.sv
// Local spreading-code generator: Fibonacci shift register whose
// stage 0 is the current code chip. It advances once per consumed chip
// and is reloaded with SEED at each segment start.
// Assumes SEED is nonzero and TAPS give the wanted sequence.
module dsd_code_gen #(
    parameter int               W    = 4,
    parameter logic [W-1:0]     TAPS = 4'b1001,
    parameter logic [W-1:0]     SEED = 4'b0100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic advance,
    output logic code_chip
);

    logic [W-1:0] st;

    // State update: seed on reset or segment start, else shift in feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEED;
        end else if (reseed) begin
            st <= SEED;
        end else if (advance) begin
            st <= {^(st & TAPS), st[W-1:1]};
        end
    end

    assign code_chip = st[0];

    p_state_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0)
        else $error("code generator reached all-zero state");

    p_reseed_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> st == SEED)
        else $error("segment start did not reload the seed");

endmodule

// File: rtl/dsd_chip_source.sv
// Chip source: merges the parallel and serial frame inputs into a
// single chip stream. A parallel frame is held in a shift register and
// emitted MSB first, one chip per clock. Serial input is ignored while
// the register drains, and loads are accepted only when it is empty.
module dsd_chip_source #(
    parameter int FRAME = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_load,
    input  logic [FRAME-1:0] frame_word,
    input  logic             chip_valid,
    input  logic             chip_in,
    output logic             chip_vld,
    output logic             chip_bit,
    output logic             restart
);

    localparam int CW = $clog2(FRAME + 1);

    logic [FRAME-1:0] sr;
    logic [CW-1:0]    left;
    logic             draining;

    assign draining = (left != '0);
    assign restart  = frame_load && !draining;
    assign chip_vld = draining || (chip_valid && !frame_load);
    assign chip_bit = draining ? sr[FRAME-1] : chip_in;

    // Frame register: capture on accepted load, then shift one chip per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
        end else if (restart) begin
            sr   <= frame_word;
            left <= CW'(FRAME);
        end else if (draining) begin
            sr   <= sr << 1;
            left <= left - CW'(1);
        end
    end

    p_load_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> left == CW'(FRAME))
        else $error("accepted load did not arm a full frame");

    p_drain_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (left != '0) |=> left == $past(left) - CW'(1))
        else $error("drain count did not step down by one");

endmodule

// File: rtl/dsd_correlator.sv
// Correlator: counts chips that agree with the local code in the
// current segment and decides one bit by majority on the segment's
// last chip. It also tracks position within the frame and tells the
// code generator when to advance and when to reseed.
module dsd_correlator #(
    parameter int CHIPS  = 15,
    parameter int BITS   = 4,
    parameter int THRESH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic chip_vld,
    input  logic chip_bit,
    input  logic code_chip,
    output logic advance,
    output logic reseed,
    output logic bit_vld,
    output logic bit_val,
    output logic frame_end
);

    localparam int CNT_W = $clog2(CHIPS + 1);
    localparam int IDX_W = $clog2(CHIPS);
    localparam int SEG_W = (BITS > 1) ? $clog2(BITS) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] total;
    logic [IDX_W-1:0] chip_idx;
    logic [SEG_W-1:0] seg_idx;
    logic             agree;
    logic             seg_last;

    assign agree     = ~(chip_bit ^ code_chip);
    assign total     = cnt + CNT_W'(agree);
    assign seg_last  = (chip_idx == IDX_W'(CHIPS - 1));
    assign bit_vld   = chip_vld && seg_last;
    assign bit_val   = (total >= CNT_W'(THRESH));
    assign frame_end = bit_vld && (seg_idx == SEG_W'(BITS - 1));
    assign advance   = chip_vld;
    assign reseed    = restart || bit_vld;

    // Segment bookkeeping: accumulate agreements, clear at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt      <= '0;
            chip_idx <= '0;
            seg_idx  <= '0;
        end else if (chip_vld) begin
            if (seg_last) begin
                cnt      <= '0;
                chip_idx <= '0;
                seg_idx  <= frame_end ? '0 : seg_idx + SEG_W'(1);
            end else begin
                cnt      <= total;
                chip_idx <= chip_idx + IDX_W'(1);
            end
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(chip_idx) >= cnt)
        else $error("agreement count exceeds chips seen");

    p_seg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> (cnt == '0 && chip_idx == '0))
        else $error("segment boundary did not clear the count");

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_vld && !restart) |=> ($stable(cnt) && $stable(chip_idx) && $stable(seg_idx)))
        else $error("progress changed without a chip");

endmodule

// File: rtl/dsd_despreader.sv
// Despreader top: chip source, local code generator and correlator,
// plus the message assembly register and the done pulse.
// Assumes frames are aligned to segment boundaries.
module dsd_despreader #(
    parameter int                  CHIPS_PER_BIT  = dsd_pkg::DEF_CHIPS_PER_BIT,
    parameter int                  BITS_PER_FRAME = dsd_pkg::DEF_BITS_PER_FRAME,
    parameter int                  LFSR_W         = dsd_pkg::DEF_LFSR_W,
    parameter logic [LFSR_W-1:0]   LFSR_TAPS      = 4'b1001,
    parameter logic [LFSR_W-1:0]   LFSR_SEED      = 4'b0100,
    localparam int                 FRAME_CHIPS    = CHIPS_PER_BIT * BITS_PER_FRAME
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_load,
    input  logic [FRAME_CHIPS-1:0]    frame_word,
    input  logic                      chip_valid,
    input  logic                      chip_in,
    output logic [BITS_PER_FRAME-1:0] msg_out,
    output logic                      msg_done
);

    localparam int THRESH = dsd_pkg::majority_threshold(CHIPS_PER_BIT);

    logic chip_vld, chip_bit, restart;
    logic advance, reseed, code_chip;
    logic bit_vld, bit_val, frame_end;
    logic [BITS_PER_FRAME-1:0] msg_sr;

    dsd_chip_source #(.FRAME(FRAME_CHIPS)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_load (frame_load),
        .frame_word (frame_word),
        .chip_valid (chip_valid),
        .chip_in    (chip_in),
        .chip_vld   (chip_vld),
        .chip_bit   (chip_bit),
        .restart    (restart)
    );

    dsd_code_gen #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .reseed    (reseed),
        .advance   (advance),
        .code_chip (code_chip)
    );

    dsd_correlator #(.CHIPS(CHIPS_PER_BIT), .BITS(BITS_PER_FRAME), .THRESH(THRESH)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .chip_vld  (chip_vld),
        .chip_bit  (chip_bit),
        .code_chip (code_chip),
        .advance   (advance),
        .reseed    (reseed),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .frame_end (frame_end)
    );

    // Message assembly: shift decided bits in, first segment ends up as MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_sr   <= '0;
            msg_out  <= '0;
            msg_done <= 1'b0;
        end else begin
            msg_done <= frame_end;
            if (bit_vld) begin
                msg_sr <= {msg_sr[BITS_PER_FRAME-2:0], bit_val};
            end
            if (frame_end) begin
                msg_out <= {msg_sr[BITS_PER_FRAME-2:0], bit_val};
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done)
        else $error("done pulse longer than one cycle");

    p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_done |-> $stable(msg_out))
        else $error("message changed without done");

endmodule

// File: tb/dsd_despreader_tb.sv
// Bench for the despreader: a behavioural model fed from the sampled
// inputs predicts msg_out and msg_done and is compared every cycle.
// Directed checks add hand-derived expectations.
module dsd_despreader_tb_top;

    localparam logic [14:0] CODE = 15'b001000111101011; // chip j = CODE[14-j]

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_load = 1'b0;
    logic [59:0] frame_word = '0;
    logic        chip_valid = 1'b0;
    logic        chip_in = 1'b0;
    logic [3:0]  msg_out;
    logic        msg_done;

    int tests = 0;
    int fails = 0;
    bit chk_en = 1'b0;

    logic [3:0] exp_msg = '0;
    logic       exp_done = 1'b0;
    bit         q[$];
    bit         pq[$];

    always #4 clk = ~clk;

    dsd_despreader dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_load (frame_load),
        .frame_word (frame_word),
        .chip_valid (chip_valid),
        .chip_in    (chip_in),
        .msg_out    (msg_out),
        .msg_done   (msg_done)
    );

    // Behavioural reference model, advanced from inputs seen at each rising edge.
    always @(posedge clk) begin
        bit c;
        bit have;
        have = 1'b0;
        c = 1'b0;
        if (!rst_n) begin
            q.delete();
            pq.delete();
            exp_done = 1'b0;
            exp_msg = '0;
        end else begin
            exp_done = 1'b0;
            if (pq.size() > 0) begin
                c = pq.pop_front();
                have = 1'b1;
            end else if (frame_load) begin
                q.delete();
                for (int i = 59; i >= 0; i--) pq.push_back(frame_word[i]);
            end else if (chip_valid) begin
                c = chip_in;
                have = 1'b1;
            end
            if (have) begin
                q.push_back(c);
                if (q.size() == 60) begin
                    for (int s = 0; s < 4; s++) begin
                        int agree_n;
                        agree_n = 0;
                        for (int j = 0; j < 15; j++)
                            if (q[15*s+j] == CODE[14-j]) agree_n++;
                        exp_msg[3-s] = (agree_n >= 8);
                    end
                    exp_done = 1'b1;
                    q.delete();
                end
            end
        end
    end

    // Cycle compare against the model (R3 result, R8 pulse and hold).
    always @(negedge clk) begin
        if (chk_en) begin
            tests++;
            if (msg_done !== exp_done || msg_out !== exp_msg) begin
                fails++;
                $display("FAIL R8 cycle compare: done=%b msg=%b expected done=%b msg=%b",
                         msg_done, msg_out, exp_done, exp_msg);
            end
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, expv);
        end
    endtask

    function automatic logic [59:0] spread(input logic [3:0] m);
        logic [59:0] w;
        for (int s = 0; s < 4; s++)
            for (int j = 0; j < 15; j++)
                w[59-(15*s+j)] = m[3-s] ? CODE[14-j] : ~CODE[14-j];
        return w;
    endfunction

    function automatic logic [59:0] corrupt(input logic [59:0] w, input int seg, input int n);
        logic [59:0] r;
        r = w;
        for (int j = 0; j < n; j++) r[59-(15*seg+j)] = ~r[59-(15*seg+j)];
        return r;
    endfunction

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (msg_done !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        tests++;
        if (msg_done !== 1'b1) begin
            fails++;
            $display("FAIL %s: done never seen, actual=0 expected=1", tag);
        end
    endtask

    task automatic send_par(input logic [59:0] w);
        @(negedge clk);
        frame_load = 1'b1;
        frame_word = w;
        @(negedge clk);
        frame_load = 1'b0;
    endtask

    task automatic send_ser(input logic [59:0] w, input int first, input int count, input bit gaps);
        for (int i = first; i < first + count; i++) begin
            @(negedge clk);
            if (gaps && (i % 7 == 3)) begin
                chip_valid = 1'b0;
                chip_in = ~w[59-i];
                @(negedge clk);
            end
            chip_valid = 1'b1;
            chip_in = w[59-i];
        end
        @(negedge clk);
        chip_valid = 1'b0;
    endtask

    initial begin
        logic [3:0] msgs [8] = '{4'b0000, 4'b0001, 4'b0101, 4'b0110,
                                 4'b1001, 4'b1010, 4'b1110, 4'b1111};
        logic [3:0] held;

        repeat (3) @(posedge clk);
        chk_en = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 reset msg_out", msg_out, 4'b0000);
        check("R10 reset done", {3'b0, msg_done}, 4'b0000);
        rst_n = 1'b1;

        // R1 R3 R4: code,code,code,inverted -> 1110, with exact done timing
        send_par({CODE, CODE, CODE, ~CODE});
        repeat (59) @(negedge clk);
        check("R4 done absent at edge 59", {3'b0, msg_done}, 4'b0000);
        @(negedge clk);
        check("R4 done present at edge 60", {3'b0, msg_done}, 4'b0001);
        check("R3 frame code,code,code,inv", msg_out, 4'b1110);

        // R8: value holds after the pulse
        held = msg_out;
        repeat (10) @(negedge clk);
        check("R8 msg hold", msg_out, held);
        check("R8 done low after pulse", {3'b0, msg_done}, 4'b0000);

        // R1 R3 R6: round trips through the parallel path
        foreach (msgs[k]) begin
            send_par(spread(msgs[k]));
            wait_done("R3 parallel round trip");
            check("R3 parallel round trip", msg_out, msgs[k]);
        end

        // R5: serial path with idle gaps
        send_ser(spread(4'b0101), 0, 60, 1'b1);
        wait_done("R5 serial gaps");
        check("R5 serial with gaps", msg_out, 4'b0101);
        send_ser(spread(4'b1010), 0, 60, 1'b0);
        wait_done("R5 serial");
        check("R5 serial contiguous", msg_out, 4'b1010);

        // R2: 7 errors per segment are tolerated
        begin
            logic [59:0] w;
            w = spread(4'b1001);
            for (int s = 0; s < 4; s++) w = corrupt(w, s, 7);
            send_par(w);
            wait_done("R2 seven errors");
            check("R2 seven errors each segment", msg_out, 4'b1001);
        end
        // R2 R7: 8 errors flip segment 1 only; segment 0 fully agrees
        send_par(corrupt(spread(4'b1111), 1, 8));
        wait_done("R7 eight errors");
        check("R7 count cleared per segment / R2 flip", msg_out, 4'b1011);

        // R9: serial chips and extra loads ignored while draining
        @(negedge clk);
        frame_load = 1'b1;
        frame_word = spread(4'b0110);
        @(negedge clk);
        frame_word = spread(4'b1111);
        for (int i = 0; i < 58; i++) begin
            frame_load = (i == 20);
            chip_valid = 1'b1;
            chip_in = i[0];
            @(negedge clk);
        end
        frame_load = 1'b0;
        chip_valid = 1'b0;
        wait_done("R9 busy ignore");
        check("R9 inputs ignored while draining", msg_out, 4'b0110);

        // R11: load aborts a partial serial frame
        send_ser(spread(4'b1111), 0, 20, 1'b0);
        send_par(spread(4'b1001));
        wait_done("R11 abort");
        check("R11 load discards partial serial", msg_out, 4'b1001);

        // R10: reset mid-frame discards progress
        send_ser(spread(4'b1111), 0, 30, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 reset clears msg_out", msg_out, 4'b0000);
        rst_n = 1'b1;
        send_ser(spread(4'b0001), 0, 60, 1'b0);
        wait_done("R10 after reset");
        check("R10 frame after reset", msg_out, 4'b0001);

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule